// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block sends stereo PCM sample pairs to an audio DAC over a three-wire serial link. It is the clock master: it makes the bit clock from the system clock, and it drives the word clock, which marks the channel, and the serial data line. A left/right sample pair is taken through a valid/ready handshake once per frame. The left sample goes out first and the right sample follows. Each sample is sent most significant bit first and fills the front of its channel slot. The slot bits after the sample are zeros.

A mode input chooses between two framings, and its value is taken only at the start of a frame. In I2S framing the word clock changes one bit period before the new channel's MSB. In left-justified framing the word-clock change and the MSB fall in the same bit period, and the word-clock polarity is inverted. If no pair is offered when a frame starts, the previous pair is sent again and a one-cycle underrun pulse is raised.

Top module: `pcm_serial_tx`

## Requirements
- R1: After reset `bclk`, `wclk`, `sdata`, `in_ready` and `underrun` are all low. Afterwards `bclk` stays high for exactly `HALF_DIV` system cycles and low for exactly `HALF_DIV` system cycles.
- R2: `sdata` and `wclk` change only in the system cycle in which `bclk` falls, so both are steady across every rising `bclk` edge.
- R3: A frame lasts `FRAME_BITS` bit periods, which is 2·`FRAME_BITS`·`HALF_DIV` system cycles. Its first half is the left slot and its second half is the right slot, and each sample is sent MSB first.
- R4: With `fmt_lj`=1 (left-justified), `wclk` is high for the left slot and low for the right slot. A sample's MSB is sent in the first bit period of its slot.
- R5: With `fmt_lj`=0 (I2S), `wclk` is low for the left slot and high for the right slot. A sample's MSB is sent in the second bit period of its slot. The first bit period of a slot carries the last bit of the slot before it, which for the first left slot after reset comes from an all-zero pair.
- R6: Slot bit periods that come after the last sample bit carry 0 on `sdata`.
- R7: `in_ready` is high for one system cycle per frame. That cycle is the one in which `bclk` falls to begin the frame's first bit period. A pair is accepted when `in_valid` is high in that cycle.
- R8: If `in_valid` is low in the `in_ready` cycle, the previously accepted pair is sent again, or zeros if no pair has been accepted yet. `underrun` is then high for exactly the next system cycle, and it is low at every other time.
- R9: `fmt_lj` is sampled only in the `in_ready` cycle. A change at any other time has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_lj | input | 1 | Framing select: 0 = I2S, 1 = left-justified |
| in_valid | input | 1 | A sample pair is offered |
| in_left | input | SAMPLE_W | Left-channel sample |
| in_right | input | SAMPLE_W | Right-channel sample |
| in_ready | output | 1 | One-cycle pulse at frame start; accepts the offered pair |
| bclk | output | 1 | Bit clock to the DAC |
| wclk | output | 1 | Word (channel) clock to the DAC |
| sdata | output | 1 | Serial sample data |
| underrun | output | 1 | One-cycle pulse when a frame starts with no pair offered |

## Verification
Directed pairs with all ones, a lone MSB, a lone LSB and alternating patterns are sent first in I2S framing and then in left-justified framing. These show whether the bit order is correct and whether the MSB lands one bit period late or on time in each framing. Two frames with no pair offered show whether the previous pair is repeated and whether the underrun pulse appears. A random phase then mixes data, gaps and framing changes, and some framing changes are made in the middle of a frame. These mid-frame changes show whether the mode is taken only at the frame boundary. Every rising bit-clock edge is compared against a bit-level model that works on the recorded frames.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    localparam int MAX_W = 24;

    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_LJ  = 1'b1
    } fmt_e;

    typedef struct packed {
        logic [MAX_W-1:0] left;
        logic [MAX_W-1:0] right;
    } pair_t;

    typedef struct packed {
        logic       right;
        logic [7:0] idx;
    } slot_t;

    // Map a frame position onto a channel slot and a bit index within it.
    function automatic slot_t locate(input int unsigned p, input int unsigned half);
        slot_t s;
        s.right = (p >= half);
        s.idx   = 8'(s.right ? p - half : p);
        return s;
    endfunction

    // Bit of the pair sent at a slot position; zero past the sample width.
    function automatic logic pick_bit(input pair_t pr, input slot_t s, input int unsigned w);
        logic [MAX_W-1:0] smp;
        int unsigned      k;
        if (32'(s.idx) >= w) return 1'b0;
        smp = s.right ? pr.right : pr.left;
        k   = w - 1 - 32'(s.idx);
        return smp[5'(k)];
    endfunction

endpackage

// File: rtl/pcm_bclk_gen.sv
module pcm_bclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic bclk,
    output logic fall_tick
);
    logic bclk_q;
    logic wrap;

    generate
        if (HALF_DIV == 1) begin : g_nodiv
            assign wrap = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(HALF_DIV);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst)       cnt <= '0;
                else if (wrap) cnt <= '0;
                else           cnt <= cnt + CW'(1);
            end
            assign wrap = (cnt == CW'(HALF_DIV - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       bclk_q <= 1'b0;
        else if (wrap) bclk_q <= ~bclk_q;
    end

    assign bclk      = bclk_q;
    assign fall_tick = wrap & bclk_q;
endmodule

// File: rtl/pcm_frame_seq.sv
module pcm_frame_seq
    import pcm_tx_pkg::*;
#(
    parameter int FRAME_BITS = 64,
    localparam int PW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fall_tick,
    input  logic          in_valid,
    input  pair_t         in_pair,
    input  fmt_e          fmt_in,
    output logic          in_ready,
    output logic [PW-1:0] pos_next,
    output pair_t         pair_old,
    output pair_t         pair_next,
    output fmt_e          fmt_next,
    output logic          underrun
);
    logic [PW-1:0] pos_q;
    pair_t         pair_q;
    fmt_e          fmt_q;
    logic          boundary;

    assign boundary  = fall_tick && (pos_q == PW'(FRAME_BITS - 1));
    assign in_ready  = boundary;
    assign pos_next  = boundary ? '0 : pos_q + PW'(1);
    assign pair_next = (boundary && in_valid) ? in_pair : pair_q;
    assign fmt_next  = boundary ? fmt_in : fmt_q;
    assign pair_old  = pair_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= PW'(FRAME_BITS - 1);
            pair_q   <= '0;
            fmt_q    <= FMT_I2S;
            underrun <= 1'b0;
        end else begin
            underrun <= boundary && !in_valid;
            if (fall_tick) begin
                pos_q  <= pos_next;
                pair_q <= pair_next;
                fmt_q  <= fmt_next;
            end
        end
    end
endmodule

// File: rtl/pcm_bit_mux.sv
module pcm_bit_mux
    import pcm_tx_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int FRAME_BITS = 64,
    localparam int PW   = $clog2(FRAME_BITS),
    localparam int HALF = FRAME_BITS / 2
) (
    input  logic [PW-1:0] pos,
    input  pair_t         pair_old,
    input  pair_t         pair_new,
    input  fmt_e          fmt,
    output logic          data_bit,
    output logic          wclk_lvl
);
    always_comb begin
        int unsigned p;
        int unsigned q;
        pair_t       src;
        slot_t       s;
        p = 32'(pos);
        if (fmt == FMT_LJ) begin
            q   = p;
            src = pair_new;
        end else begin
            // I2S: data trails the word clock by one bit period.
            q   = (p == 0) ? FRAME_BITS - 1 : p - 1;
            src = (p == 0) ? pair_old : pair_new;
        end
        s        = locate(q, HALF);
        data_bit = pick_bit(src, s, SAMPLE_W);
        wclk_lvl = (fmt == FMT_LJ) ? (p < HALF) : (p >= HALF);
    end
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
    import pcm_tx_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int FRAME_BITS = 64,
    parameter int HALF_DIV   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fmt_lj,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                in_ready,
    output logic                bclk,
    output logic                wclk,
    output logic                sdata,
    output logic                underrun
);
    localparam int PW = $clog2(FRAME_BITS);

    generate
        if (FRAME_BITS != 16 && FRAME_BITS != 32 && FRAME_BITS != 64) begin : g_bad_frame
            $error("FRAME_BITS must be 16, 32 or 64");
        end
        if (FRAME_BITS < 2 * SAMPLE_W) begin : g_bad_fit
            $error("FRAME_BITS must hold two samples");
        end
        if (SAMPLE_W > MAX_W || SAMPLE_W < 1) begin : g_bad_width
            $error("SAMPLE_W out of range");
        end
        if (HALF_DIV < 1) begin : g_bad_div
            $error("HALF_DIV must be at least 1");
        end
    endgenerate

    logic          fall_tick;
    pair_t         in_pair;
    pair_t         pair_old;
    pair_t         pair_next;
    fmt_e          fmt_next;
    logic [PW-1:0] pos_next;
    logic          data_bit;
    logic          wclk_lvl;
    logic          sdata_q;
    logic          wclk_q;

    assign in_pair.left  = MAX_W'(in_left);
    assign in_pair.right = MAX_W'(in_right);

    pcm_bclk_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
        .clk       (clk),
        .rst       (rst),
        .bclk      (bclk),
        .fall_tick (fall_tick)
    );

    pcm_frame_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .fall_tick (fall_tick),
        .in_valid  (in_valid),
        .in_pair   (in_pair),
        .fmt_in    (fmt_e'(fmt_lj)),
        .in_ready  (in_ready),
        .pos_next  (pos_next),
        .pair_old  (pair_old),
        .pair_next (pair_next),
        .fmt_next  (fmt_next),
        .underrun  (underrun)
    );

    pcm_bit_mux #(.SAMPLE_W(SAMPLE_W), .FRAME_BITS(FRAME_BITS)) u_mux (
        .pos      (pos_next),
        .pair_old (pair_old),
        .pair_new (pair_next),
        .fmt      (fmt_next),
        .data_bit (data_bit),
        .wclk_lvl (wclk_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sdata_q <= 1'b0;
            wclk_q  <= 1'b0;
        end else if (fall_tick) begin
            sdata_q <= data_bit;
            wclk_q  <= wclk_lvl;
        end
    end

    assign sdata = sdata_q;
    assign wclk  = wclk_q;
endmodule

// File: rtl/pcm_tx_chk.sv
module pcm_tx_chk #(
    parameter int HALF_DIV = 2
) (
    input logic clk,
    input logic rst,
    input logic bclk,
    input logic wclk,
    input logic sdata,
    input logic in_ready,
    input logic in_valid,
    input logic underrun
);
    int unsigned hc;

    always_ff @(posedge clk) begin
        if (rst)                                hc <= 0;
        else if (hc == 32'(HALF_DIV - 1))       hc <= 0;
        else                                    hc <= hc + 1;
    end

    // R1
    bclk_half_period_chk: assert property (@(posedge clk) disable iff (rst)
        $changed(bclk) |-> hc == 0);

    // R2
    data_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(bclk) |-> ($stable(sdata) && $stable(wclk)));

    // R7
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> !in_ready);

    // R7
    ready_at_fall_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> bclk);

    // R8
    underrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
        underrun |-> ($past(in_ready) && !$past(in_valid)));
endmodule

bind pcm_serial_tx pcm_tx_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bclk     (bclk),
    .wclk     (wclk),
    .sdata    (sdata),
    .in_ready (in_ready),
    .in_valid (in_valid),
    .underrun (underrun)
);

// File: tb/tb_pcm_serial_tx.sv
module tb_pcm_serial_tx;
    localparam int W  = 16;
    localparam int F  = 64;
    localparam int HD = 2;
    localparam int H  = F / 2;
    localparam int NF = 40;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fmt_lj = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_left = '0;
    logic [W-1:0] in_right = '0;
    logic         in_ready, bclk, wclk, sdata, underrun;

    always #10 clk = ~clk;

    pcm_serial_tx #(.SAMPLE_W(W), .FRAME_BITS(F), .HALF_DIV(HD)) dut (
        .clk(clk), .rst(rst), .fmt_lj(fmt_lj), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right), .in_ready(in_ready),
        .bclk(bclk), .wclk(wclk), .sdata(sdata), .underrun(underrun)
    );

    int checks = 0;
    int errors = 0;
    logic [W-1:0] fl [NF+1];
    logic [W-1:0] fr [NF+1];
    logic         fm [NF+1];
    logic         fflip [NF+1];
    int nfr = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_data(input logic lj, input int p,
            input logic [W-1:0] cl, input logic [W-1:0] cr,
            input logic [W-1:0] pl, input logic [W-1:0] pr);
        int q, s;
        logic [W-1:0] sl, sr;
        if (lj) begin
            q = p; sl = cl; sr = cr;
        end else begin
            q = (p == 0) ? F - 1 : p - 1;
            sl = (p == 0) ? pl : cl;
            sr = (p == 0) ? pr : cr;
        end
        s = q % H;
        if (s >= W) return 1'b0;
        return (q >= H) ? sr[W-1-s] : sl[W-1-s];
    endfunction

    function automatic logic exp_wclk(input logic lj, input int p);
        return lj ? (p < H) : (p >= H);
    endfunction

    function automatic string tag_for(input logic lj, input int p, input int k);
        int q;
        q = lj ? p : ((p == 0) ? F - 1 : p - 1);
        if (fflip[k]) return "R9";
        if ((q % H) >= W) return "R6";
        return lj ? "R4" : "R5";
    endfunction

    task automatic plan_next(input int k);
        fflip[k] = 1'b0;
        if (k < 4) begin
            fmt_lj = 1'b0; in_valid = 1'b1;
            case (k)
                0: begin in_left = 16'hFFFF; in_right = 16'h0001; end
                1: begin in_left = 16'h8000; in_right = 16'h7FFF; end
                2: begin in_left = 16'hA5C3; in_right = 16'h5A3C; end
                default: begin in_left = 16'h0001; in_right = 16'h8000; end
            endcase
        end else if (k < 8) begin
            fmt_lj = 1'b1; in_valid = 1'b1;
            in_left = W'($urandom); in_right = W'($urandom);
            if (k == 4) begin in_left = 16'h8001; in_right = 16'hFFFE; end
        end else if (k < 10) begin
            in_valid = 1'b0; fmt_lj = (k == 8);
        end else begin
            in_valid = ($urandom % 4) != 0;
            fmt_lj = 1'($urandom % 2);
            in_left = W'($urandom); in_right = W'($urandom);
        end
    endtask

    // R1 bit-clock half period measurement
    initial begin
        logic lastb;
        int run;
        bit started;
        lastb = 1'b0; run = 0; started = 0;
        wait (!rst);
        forever begin
            @(negedge clk);
            if (bclk !== lastb) begin
                if (started) chk(run == HD, "R1", "bclk half period", run, HD);
                started = 1; run = 1; lastb = bclk;
            end else run++;
        end
    end

    // Bit-level monitor on rising bclk edges (R2..R6, R9)
    initial begin
        int rp, fk, p;
        logic [W-1:0] pl, pr;
        rp = 0;
        forever begin
            @(posedge bclk);
            #2;
            if (nfr > 0 && !done) begin
                fk = rp / F; p = rp % F;
                if (fk < nfr) begin
                    pl = (fk == 0) ? '0 : fl[fk-1];
                    pr = (fk == 0) ? '0 : fr[fk-1];
                    chk(sdata === exp_data(fm[fk], p, fl[fk], fr[fk], pl, pr),
                        tag_for(fm[fk], p, fk), "sdata", sdata,
                        exp_data(fm[fk], p, fl[fk], fr[fk], pl, pr));
                    chk(wclk === exp_wclk(fm[fk], p), fflip[fk] ? "R9" : (fm[fk] ? "R4" : "R5"),
                        "wclk", wclk, exp_wclk(fm[fk], p));
                end
                rp++;
            end
        end
    end

    // Driver and handshake checks (R3, R7, R8, R9)
    initial begin
        int since;
        int last_b;
        int cyc;
        bit v;
        void'($urandom(32'd7741));
        cyc = 0; last_b = -1; since = 0;
        fflip[0] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(bclk == 0 && wclk == 0 && sdata == 0, "R1", "reset outputs",
            {bclk, wclk, sdata}, 0);
        chk(in_ready == 0 && underrun == 0, "R1", "reset handshake",
            {in_ready, underrun}, 0);
        plan_next(0);
        rst = 1'b0;
        while (nfr < NF) begin
            @(negedge clk);
            cyc++; since++;
            if (in_ready) begin
                v = in_valid;
                if (last_b >= 0)
                    chk(cyc - last_b == 2 * F * HD, "R3", "frame length cycles",
                        cyc - last_b, 2 * F * HD);
                last_b = cyc;
                if (v) begin fl[nfr] = in_left; fr[nfr] = in_right; end
                else begin
                    fl[nfr] = (nfr == 0) ? '0 : fl[nfr-1];
                    fr[nfr] = (nfr == 0) ? '0 : fr[nfr-1];
                end
                fm[nfr] = fmt_lj;
                nfr++;
                since = 0;
                @(negedge clk);
                cyc++; since++;
                chk(underrun == !v, "R8", "underrun after boundary", underrun, !v);
                chk(in_ready == 0, "R7", "ready pulse width", in_ready, 0);
                if (nfr <= NF) plan_next(nfr);
            end else begin
                if (since > 2) chk(underrun == 0, "R8", "underrun idle", underrun, 0);
                if (nfr >= 10 && nfr < NF && (nfr % 3) == 1 && since == F) begin
                    fmt_lj = ~fmt_lj;
                    fflip[nfr-1] = 1'b1;
                end
            end
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", nfr, NF);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule